// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the stream of column addresses that an SDRAM read or write burst walks through. A start strobe captures the starting column, the bank, the direction (read or write) and the burst configuration: length code and wrap order. From the next clock on, the block presents one column address per cycle with a valid flag. It raises a last flag on the final address of a fixed-length burst and stops on its own. A full-page burst never stops by itself; it keeps circling the 256-word row until the terminate input ends it.

For read bursts the block also produces a read-data-valid strobe train. This is the issued-address train delayed by the programmed CAS latency of 1, 2 or 3 clocks, so a data capture stage knows exactly which cycles carry returning data. A new start strobe at any time abandons the running burst and begins the new one on the same edge. Row activation, precharge, refresh and the data pads are handled elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: When start_i is sampled high, the next cycle shows valid_o high, col_o equal to the sampled start_col_i and bank_o equal to the sampled start_bank_i. Length code, wrap order and direction are also captured at that edge.
- R2: Length code blen_i 0, 1, 2 and 3 gives bursts of 1, 2, 4 and 8 addresses. Codes 4, 5 and 6 give a burst of 1 address. Code 7 selects a full-page burst.
- R3: For a fixed-length burst of N addresses with ilv_i low (sequential order), the column bits above log2(N) stay equal to the start column. The k-th address (k from 0) has low bits equal to (start low bits + k) mod N.
- R4: For a fixed-length burst with ilv_i high (interleaved order), the high bits stay fixed and the k-th address has low bits equal to start low bits XOR k.
- R5: last_o is high on the N-th address of a fixed-length burst and on no other. valid_o is low in the following cycle unless a new start was sampled.
- R6: A full-page burst ignores ilv_i. Its k-th address is (start_col + k) mod 256, so it wraps from 255 to 0. last_o never rises during it, and it continues until terminated or restarted.
- R7: When terminate_i is sampled high while valid_o is high, the address on display is the final one and valid_o is low in the next cycle.
- R8: A start_i sampled during a burst replaces it: the next cycle shows the new start column as address 0 under the new configuration. start_i takes precedence over terminate_i in the same cycle.
- R9: For read bursts (read_i high at start), rd_valid_o is high exactly cas_lat_i cycles after each cycle in which valid_o was high. cas_lat_i values 1, 2 and 3 give those latencies, and 0 acts as 1. Write bursts never raise rd_valid_o.
- R10: While rst_ni is low, and in the first cycle after it is released with no start, valid_o, last_o and rd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | 8 | Starting column |
| start_bank_i | input | 2 | Bank for the burst |
| read_i | input | 1 | 1 = read burst, 0 = write burst |
| blen_i | input | 3 | Length code: 0..3 = 1,2,4,8; 7 = full page; 4..6 = 1 |
| ilv_i | input | 1 | 0 = sequential, 1 = interleaved wrap order |
| cas_lat_i | input | 2 | Read latency in clocks (1..3, 0 acts as 1) |
| terminate_i | input | 1 | Stop the running burst after the current address |
| col_o | output | 8 | Current column address |
| bank_o | output | 2 | Bank of the current burst |
| valid_o | output | 1 | col_o carries an address this cycle |
| last_o | output | 1 | Final address of a fixed-length burst |
| rd_valid_o | output | 1 | Read data expected this cycle |

## Verification
The assertions assume that cas_lat_i is held steady while read data of an earlier burst is still in the delay line. The latency check relates rd_valid_o to the issue train only across cycles where the latency is unchanged. They also assume that start_i and terminate_i are clean single-cycle samples, so they reason only about the edge after each strobe. The stimulus changes cas_lat_i only between bursts, after enough idle cycles for the longest latency to drain. It pairs terminate_i with start_i only in the one case that tests start precedence.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  parameter int unsigned COL_BITS  = 8;
  parameter int unsigned BANK_BITS = 2;
  parameter int unsigned LEN_BITS  = 3;
  parameter int unsigned MAX_LAT   = 3;
  parameter int unsigned LAT_BITS  = 2;

  localparam logic [LEN_BITS-1:0] LEN_PAGE = 3'd7;
  localparam int unsigned MAX_FIX_LOG = 3;
endpackage

// File: rtl/sdram_wrap_mask.sv
module sdram_wrap_mask
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W = COL_BITS
) (
  input  logic [LEN_BITS-1:0] blen_i,
  output logic [COL_W-1:0]    mask_o,
  output logic                full_o
);
  logic [LEN_BITS-1:0] len_log;

  always_comb begin
    full_o  = (blen_i == LEN_PAGE);
    len_log = (blen_i <= LEN_BITS'(MAX_FIX_LOG)) ? blen_i : '0;
    if (full_o) mask_o = '1;
    else        mask_o = COL_W'((32'd1 << len_log) - 32'd1);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W  = COL_BITS,
  parameter int unsigned BANK_W = BANK_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [BANK_W-1:0]   start_bank_i,
  input  logic                read_i,
  input  logic [LEN_BITS-1:0] blen_i,
  input  logic                ilv_i,
  input  logic                terminate_i,
  output logic [COL_W-1:0]    col_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic                valid_o,
  output logic                last_o,
  output logic                rd_issue_o
);
  logic              active_q, full_q, ilv_q, rd_q;
  logic [COL_W-1:0]  base_q, mask_q, cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  mask_d, low_sum, low_sel;
  logic              full_d;

  sdram_wrap_mask #(.COL_W(COL_W)) u_mask (
    .blen_i (blen_i),
    .mask_o (mask_d),
    .full_o (full_d)
  );

  always_comb begin
    low_sum    = base_q + cnt_q;
    low_sel    = ilv_q ? (base_q ^ cnt_q) : low_sum;
    col_o      = (base_q & ~mask_q) | (low_sel & mask_q);
    bank_o     = bank_q;
    valid_o    = active_q;
    last_o     = active_q & ~full_q & (cnt_q == mask_q);
    rd_issue_o = active_q & rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      bank_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_d;
      ilv_q    <= ilv_i & ~full_d;  // full page is always sequential
      rd_q     <= read_i;
      base_q   <= start_col_i;
      mask_q   <= mask_d;
      cnt_q    <= '0;
      bank_q   <= start_bank_i;
    end else if (active_q) begin
      if (terminate_i || last_o) active_q <= 1'b0;
      else                       cnt_q    <= cnt_q + 1'b1;
    end
  end

  // R1
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i) && bank_o == $past(start_bank_i));

  // R5
  last_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  // R7
  term_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && terminate_i && !start_i |=> !valid_o);

  // R6
  page_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && !start_i && !terminate_i |=>
      valid_o && !last_o && col_o == COL_W'($past(col_o) + 1'b1));

  // R3
  high_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !start_i && !last_o && !terminate_i |=>
      (col_o & ~mask_q) == ($past(col_o) & ~mask_q));
endmodule

// File: rtl/sdram_rd_delay.sv
module sdram_rd_delay
  import sdram_burst_pkg::*;
#(
  parameter int unsigned MAX_CL = MAX_LAT,
  parameter int unsigned CL_W   = LAT_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [CL_W-1:0] cas_lat_i,
  output logic            rd_valid_o
);
  logic [MAX_CL-1:0] stage_q;
  int unsigned       tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= issue_i;
  end

  for (genvar s = 1; s < MAX_CL; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= 1'b0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  always_comb begin
    if (cas_lat_i == '0)                   tap = 0;
    else if (int'(cas_lat_i) > int'(MAX_CL)) tap = MAX_CL - 1;
    else                                   tap = int'(cas_lat_i) - 1;
    rd_valid_o = stage_q[tap];
  end

  // R9
  lat_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_i == CL_W'(1)) && $past(cas_lat_i == CL_W'(1)) |-> rd_valid_o == $past(issue_i));

  // R10
  always_comb begin
    if (!rst_ni) reset_quiet_chk: assert (rd_valid_o == 1'b0 || $isunknown(rd_valid_o));
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W  = COL_BITS,
  parameter int unsigned BANK_W = BANK_BITS,
  parameter int unsigned MAX_CL = MAX_LAT,
  parameter int unsigned CL_W   = LAT_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [BANK_W-1:0]   start_bank_i,
  input  logic                read_i,
  input  logic [LEN_BITS-1:0] blen_i,
  input  logic                ilv_i,
  input  logic [CL_W-1:0]     cas_lat_i,
  input  logic                terminate_i,
  output logic [COL_W-1:0]    col_o,
  output logic [BANK_W-1:0]   bank_o,
  output logic                valid_o,
  output logic                last_o,
  output logic                rd_valid_o
);
  logic rd_issue;

  sdram_col_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .start_bank_i (start_bank_i),
    .read_i       (read_i),
    .blen_i       (blen_i),
    .ilv_i        (ilv_i),
    .terminate_i  (terminate_i),
    .col_o        (col_o),
    .bank_o       (bank_o),
    .valid_o      (valid_o),
    .last_o       (last_o),
    .rd_issue_o   (rd_issue)
  );

  sdram_rd_delay #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (rd_issue),
    .cas_lat_i  (cas_lat_i),
    .rd_valid_o (rd_valid_o)
  );

  // R5
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, rd = 1'b0, ilv = 1'b0, term = 1'b0;
  logic [7:0] scol = '0;
  logic [1:0] sbank = '0, cl = 2'd1;
  logic [2:0] blen = '0;
  logic [7:0] col;
  logic [1:0] bank;
  logic       valid, last, rdv;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .start_bank_i(sbank), .read_i(rd), .blen_i(blen), .ilv_i(ilv),
    .cas_lat_i(cl), .terminate_i(term), .col_o(col), .bank_o(bank),
    .valid_o(valid), .last_o(last), .rd_valid_o(rdv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int s, int code, int il, int k);
    int n, m;
    if (code == 7) return (s + k) % 256;
    n = (code <= 3) ? (1 << code) : 1;
    m = n - 1;
    if (il != 0) return (s & ~m) | ((s ^ k) & m);
    return (s & ~m) | ((s + k) & m);
  endfunction

  task automatic launch(int c, int b, int code, int il, int r, int lat);
    @(negedge clk);
    start = 1'b1; scol = 8'(c); sbank = 2'(b); blen = 3'(code);
    ilv = il[0]; rd = r[0]; cl = 2'(lat);
    @(negedge clk);
    start = 1'b0;
  endtask

  // fixed-length burst, checked from address 0 through latency drain
  task automatic run_fixed(int c, int b, int code, int il, int r, int lat);
    int n, el;
    n = (code <= 3) ? (1 << code) : 1;
    el = (lat == 0) ? 1 : lat;
    launch(c, b, code, il, r, lat);
    for (int i = 0; i <= n + 3; i++) begin
      if (i > 0) @(negedge clk);
      if (i < n) begin
        chk(valid === 1'b1, "R1 valid", int'(valid), 1);
        chk(col == 8'(exp_col(c, code, il, i)), il ? "R4 col" : "R3 col",
            int'(col), exp_col(c, code, il, i));
        chk(bank == 2'(b), "R1 bank", int'(bank), b);
        chk(last == (i == n - 1), "R5 last", int'(last), int'(i == n - 1));
      end else if (i == n) begin
        chk(valid === 1'b0, "R2 R5 end", int'(valid), 0);
      end
      chk(rdv == (r != 0 && i >= el && i - el < n), "R9 rd_valid",
          int'(rdv), int'(r != 0 && i >= el && i - el < n));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 during reset
    chk({valid, last, rdv} == 3'b000, "R10 in reset", int'({valid, last, rdv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid, last, rdv} == 3'b000, "R10 after reset", int'({valid, last, rdv}), 0);

    // R3 R4 R5 R9 sweep: both orders, all fixed lengths, every start column
    for (int il = 0; il < 2; il++)
      for (int code = 0; code < 4; code++)
        for (int c = 0; c < 256; c++)
          run_fixed(c, c >> 6, code, il, c & 1, (c % 4));

    // R2 reserved codes behave as length 1
    for (int code = 4; code < 7; code++) run_fixed(8'h37, 1, code, 1, 1, 2);

    // R6 full page: ignores interleave, wraps, no last, then R7 terminate
    launch(250, 3, 7, 1, 1, 3);
    for (int k = 0; k < 300; k++) begin
      if (k > 0) @(negedge clk);
      chk(col == 8'(exp_col(250, 7, 0, k)), "R6 page col", int'(col), exp_col(250, 7, 0, k));
      chk(valid === 1'b1 && last === 1'b0, "R6 page flags", int'({valid, last}), 2);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk(valid === 1'b0, "R7 terminate", int'(valid), 0);
    repeat (4) @(negedge clk);

    // R7 terminate inside a fixed burst
    launch(8'h10, 0, 3, 0, 0, 1);
    @(negedge clk);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    chk(valid === 1'b0, "R7 fixed terminate", int'(valid), 0);

    // R8 restart mid-burst with terminate also high
    launch(8'h05, 2, 3, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; term = 1'b1; scol = 8'h42; sbank = 2'd1; blen = 3'd2; ilv = 1'b1;
    @(negedge clk);
    start = 1'b0; term = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk(col == 8'(exp_col(8'h42, 2, 1, k)), "R8 restart col", int'(col), exp_col(8'h42, 2, 1, k));
      chk(valid === 1'b1 && bank == 2'd1, "R8 restart valid", int'({valid, bank}), 5);
      chk(last == (k == 3), "R8 R5 restart last", int'(last), int'(k == 3));
    end
    @(negedge clk);
    chk(valid === 1'b0, "R8 restart end", int'(valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule